// File: doc/BRIEF.md
# Fixed-Latency Line Memory

This block is a backing store organized as an array of lines, each line holding four 32-bit words. Several requesters share it: a data port (index 0), an instruction-fetch port (index 1) and an upper cache level (index 2). Each can ask for a word or a whole line, to read or to write. Only one requester at a time owns the store. The owner keeps presenting its request until its access has aged through a fixed number of wait cycles, and then the access completes. Every requester gets a response code in every cycle.

A separate side port writes a word or a line at once. It ignores the latency and the ownership lock, which makes it suitable for preloading and for test access. Addresses are word indices that wrap modulo the store size. An address beyond the array, or an address whose upper bits are set as a negative value would set them, therefore lands back inside the array.

Top module: `lmem_top`

## Requirements
- R1: An address is reduced to its low log2(LINES*4) bits, the word index. Its upper bits select the line and its two lowest bits select the word. Word k of a line occupies bits [32k+31:32k] of the line data.
- R2: With LATENCY = N > 0, the owner sees WAIT (code 0) on its first N presenting cycles and OK (code 1) on cycle N+1. A write takes effect at the clock edge that closes the OK cycle.
- R3: With LATENCY = 0, an access returns OK in the same cycle it is first presented.
- R4: When the store is idle, the lowest-indexed presenting requester becomes owner. Every other requester sees WAIT and makes no progress until ownership is released.
- R5: A requester that presents in the cycle the owner completes still sees WAIT. Its own N wait cycles begin in the following cycle.
- R6: A side write returns OK in the cycle it is presented, whatever the ownership state. If it targets the same word that an owner write commits at the same edge, the side value is the one stored.
- R7: The request kind encodes bit 0 = write and bit 1 = line. A line read returns the whole containing line at any of the four offsets, and a line write replaces all four words.
- R8: A word write changes only the addressed word of its line.
- R9: Response codes are limited to WAIT = 0 and OK = 1. At most one requester sees OK in any cycle, and a requester never sees OK on two consecutive cycles when N > 0.
- R10: The read outputs are zero in every cycle except the OK cycle of a read of the matching size.
- R11: After reset the store holds zeros, no requester owns it, and every response is WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_kind | input | NREQ x 2 | Bit 0 write, bit 1 line access |
| req_addr | input | NREQ x AW | Word address per requester |
| req_wword | input | NREQ x 32 | Word write data |
| req_wline | input | NREQ x 128 | Line write data |
| rsp | output | NREQ x 2 | Response code per requester |
| rd_word | output | 32 | Word read data, valid in the OK cycle |
| rd_line | output | 128 | Line read data, valid in the OK cycle |
| side_valid | input | 1 | Side-port write request |
| side_line_op | input | 1 | Side write is a whole line |
| side_addr | input | AW | Side-port word address |
| side_wword | input | 32 | Side word data |
| side_wline | input | 128 | Side line data |
| side_rsp | output | 2 | Side-port response code |

## Verification
On every cycle the assertions check the response-code range, that at most one requester gets OK at a time, that an OK with nonzero latency is always preceded by that requester presenting, that OKs do not come back to back, that read outputs stay zero outside an OK, and that the side port answers at once. Other behaviours need directed scenarios that compare stored data with values computed independently: where the data lands after wrap-around, whole-line return at every offset, that other words survive a word write, the exact wait count seen by a second requester after a handover, and the side write winning a collision.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int WORD_W = 32;
  localparam int WPL    = 4;
  localparam int LINE_W = WORD_W * WPL;

  typedef enum logic [1:0] {
    RSP_WAIT    = 2'd0,
    RSP_OK      = 2'd1,
    RSP_BLOCKED = 2'd2
  } rsp_e;
endpackage

// File: rtl/lm_owner_arb.sv
module lm_owner_arb #(
  parameter int NREQ    = 3,
  parameter int LATENCY = 3,
  localparam int SW = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CW = $clog2(LATENCY + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_valid,
  output logic            fire,
  output logic [SW-1:0]   sel,
  output logic [NREQ-1:0] ok
);
  logic          owned_q, owned_d;
  logic [SW-1:0] owner_q, owner_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] pick;
  logic          found;
  logic          cand_v;
  logic [CW-1:0] eff;
  logic          st_en;

  // lowest index among the presenting requesters
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        pick  = SW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    sel     = owned_q ? owner_q : pick;
    cand_v  = owned_q ? req_valid[owner_q] : found;
    eff     = owned_q ? cnt_q : CW'(LATENCY);
    fire    = cand_v && (eff == '0);
    ok      = fire ? (NREQ'(1) << sel) : '0;
    st_en   = cand_v;
    owned_d = owned_q;
    owner_d = owner_q;
    cnt_d   = cnt_q;
    if (fire) begin
      owned_d = 1'b0;
      cnt_d   = CW'(LATENCY);
    end else begin
      owned_d = 1'b1;
      owner_d = sel;
      cnt_d   = eff - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      cnt_q   <= CW'(LATENCY);
    end else if (st_en) begin
      owned_q <= owned_d;
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lm_line_store.sv
module lm_line_store import lm_pkg::*; #(
  parameter int LINES = 16,
  localparam int IW = $clog2(LINES * WPL),
  localparam int LW = IW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_line_op,
  input  logic [IW-1:0]     a_idx,
  input  logic [WORD_W-1:0] a_word,
  input  logic [LINE_W-1:0] a_line,
  input  logic              b_en,
  input  logic              b_line_op,
  input  logic [IW-1:0]     b_idx,
  input  logic [WORD_W-1:0] b_word,
  input  logic [LINE_W-1:0] b_line,
  input  logic [IW-1:0]     r_idx,
  output logic [LINE_W-1:0] r_line,
  output logic [WORD_W-1:0] r_word
);
  logic [LINE_W-1:0] rd_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [LINE_W-1:0] line_q, line_d;
    logic              hit_a, hit_b, en;

    always_comb begin
      hit_a  = a_en && (a_idx[IW-1:2] == LW'(g));
      hit_b  = b_en && (b_idx[IW-1:2] == LW'(g));
      en     = hit_a || hit_b;
      line_d = line_q;
      if (hit_a) begin
        if (a_line_op) line_d = a_line;
        else           line_d[a_idx[1:0]*WORD_W +: WORD_W] = a_word;
      end
      // side port applied last so it wins a same-edge collision
      if (hit_b) begin
        if (b_line_op) line_d = b_line;
        else           line_d[b_idx[1:0]*WORD_W +: WORD_W] = b_word;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  line_q <= '0;
      else if (en) line_q <= line_d;
    end

    assign rd_arr[g] = line_q;
  end

  assign r_line = rd_arr[r_idx[IW-1:2]];
  assign r_word = r_line[r_idx[1:0]*WORD_W +: WORD_W];
endmodule

// File: rtl/lmem_top.sv
module lmem_top import lm_pkg::*; #(
  parameter int NREQ    = 3,
  parameter int LINES   = 16,
  parameter int LATENCY = 3,
  parameter int AW      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREQ-1:0]             req_valid,
  input  logic [NREQ-1:0][1:0]        req_kind,
  input  logic [NREQ-1:0][AW-1:0]     req_addr,
  input  logic [NREQ-1:0][WORD_W-1:0] req_wword,
  input  logic [NREQ-1:0][LINE_W-1:0] req_wline,
  output logic [NREQ-1:0][1:0]        rsp,
  output logic [WORD_W-1:0]           rd_word,
  output logic [LINE_W-1:0]           rd_line,
  input  logic                        side_valid,
  input  logic                        side_line_op,
  input  logic [AW-1:0]               side_addr,
  input  logic [WORD_W-1:0]           side_wword,
  input  logic [LINE_W-1:0]           side_wline,
  output logic [1:0]                  side_rsp
);
  localparam int IW = $clog2(LINES * WPL);
  localparam int SW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic            fire;
  logic [SW-1:0]   sel;
  logic [NREQ-1:0] ok;
  logic [1:0]      kind;
  logic [IW-1:0]   idx;
  logic [LINE_W-1:0] r_line;
  logic [WORD_W-1:0] r_word;
  logic            addr_unused;

  lm_owner_arb #(.NREQ(NREQ), .LATENCY(LATENCY)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .fire(fire), .sel(sel), .ok(ok)
  );

  assign kind = req_kind[sel];
  assign idx  = req_addr[sel][IW-1:0];

  lm_line_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_en(fire && kind[0]), .a_line_op(kind[1]), .a_idx(idx),
    .a_word(req_wword[sel]), .a_line(req_wline[sel]),
    .b_en(side_valid), .b_line_op(side_line_op), .b_idx(side_addr[IW-1:0]),
    .b_word(side_wword), .b_line(side_wline),
    .r_idx(idx), .r_line(r_line), .r_word(r_word)
  );

  assign rd_word = (fire && !kind[0] && !kind[1]) ? r_word : '0;
  assign rd_line = (fire && !kind[0] &&  kind[1]) ? r_line : '0;

  for (genvar i = 0; i < NREQ; i++) begin : g_rsp
    assign rsp[i] = ok[i] ? RSP_OK : RSP_WAIT;
  end

  assign side_rsp    = side_valid ? RSP_OK : RSP_WAIT;
  assign addr_unused = ^{req_addr, side_addr};
endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
  parameter int NREQ    = 3,
  parameter int LATENCY = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREQ-1:0]      req_valid,
  input logic [NREQ-1:0][1:0] rsp,
  input logic [31:0]          rd_word,
  input logic [127:0]         rd_line,
  input logic                 side_valid,
  input logic [1:0]           side_rsp
);
  logic [NREQ-1:0] okv;
  logic            seen;

  for (genvar i = 0; i < NREQ; i++) begin : g_ok
    assign okv[i] = (rsp[i] == 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R9
  single_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(okv));

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (okv == '0) |-> (rd_word == '0 && rd_line == '0));

  // R6
  side_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> (side_rsp == 2'd1));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp[i][1] == 1'b0);

    // R2
    waited_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LATENCY > 0 && seen && okv[i]) |-> $past(req_valid[i]));

    // R9
    no_repeat_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LATENCY > 0 && okv[i]) |=> !okv[i]);
  end
endmodule

bind lmem_top lm_checker #(.NREQ(NREQ), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp(rsp),
  .rd_word(rd_word), .rd_line(rd_line),
  .side_valid(side_valid), .side_rsp(side_rsp)
);

// File: tb/tb_lmem_top.sv
module tb_lmem_top;
  localparam int LAT = 3;
  localparam int N   = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [N-1:0]        req_valid;
  logic [N-1:0][1:0]   req_kind;
  logic [N-1:0][31:0]  req_addr;
  logic [N-1:0][31:0]  req_wword;
  logic [N-1:0][127:0] req_wline;
  logic [N-1:0][1:0]   rsp;
  logic [31:0]         rd_word;
  logic [127:0]        rd_line;
  logic                side_valid, side_line_op;
  logic [31:0]         side_addr, side_wword;
  logic [127:0]        side_wline;
  logic [1:0]          side_rsp;

  logic [N-1:0]        zv;
  logic [N-1:0][1:0]   zk;
  logic [N-1:0][31:0]  za, zw;
  logic [N-1:0][127:0] zl;
  logic [N-1:0][1:0]   zrsp;
  logic [31:0]         z_rd_word;
  logic [127:0]        z_rd_line;
  logic [1:0]          z_side_rsp;

  lmem_top #(.NREQ(N), .LINES(16), .LATENCY(LAT), .AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wword(req_wword), .req_wline(req_wline),
    .rsp(rsp), .rd_word(rd_word), .rd_line(rd_line),
    .side_valid(side_valid), .side_line_op(side_line_op), .side_addr(side_addr),
    .side_wword(side_wword), .side_wline(side_wline), .side_rsp(side_rsp)
  );

  lmem_top #(.NREQ(N), .LINES(16), .LATENCY(0), .AW(32)) dut0 (
    .clk(clk), .rst_n(rst_n), .req_valid(zv), .req_kind(zk),
    .req_addr(za), .req_wword(zw), .req_wline(zl),
    .rsp(zrsp), .rd_word(z_rd_word), .rd_line(z_rd_line),
    .side_valid(1'b0), .side_line_op(1'b0), .side_addr(32'd0),
    .side_wword(32'd0), .side_wline(128'd0), .side_rsp(z_side_rsp)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one solo access on the latency-3 instance, checking every cycle
  task automatic solo(input int p, input logic [1:0] kind, input logic [31:0] addr,
                      input logic [31:0] ww, input logic [127:0] wl, input string tag,
                      output logic [127:0] rl, output logic [31:0] rw);
    req_valid[p] = 1'b1; req_kind[p] = kind; req_addr[p] = addr;
    req_wword[p] = ww;   req_wline[p] = wl;
    rl = '0; rw = '0;
    for (int k = 0; k <= LAT; k++) begin
      #1;
      if (k < LAT) begin
        chk(tag, rsp[p], 2'd0);
        chk("R10", {rd_line, rd_word} == '0, 1'b1);
      end else begin
        chk(tag, rsp[p], 2'd1);
        rl = rd_line; rw = rd_word;
      end
      @(negedge clk);
    end
    req_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    logic [127:0] rl; logic [31:0] rw;
    #1;
    chk("R11", rsp, '0);
    chk("R11", {rd_line, rd_word}, '0);
    chk("R11", side_rsp, 2'd0);
    @(negedge clk);
    solo(0, 2'b10, 32'd20, 0, 0, "R11", rl, rw);
    chk("R11", rl, '0);
  endtask

  task automatic t_word();
    logic [127:0] rl; logic [31:0] rw;
    solo(0, 2'b01, 32'd6, 32'hA5A5_0001, 0, "R2", rl, rw);
    solo(1, 2'b00, 32'd6, 0, 0, "R2", rl, rw);
    chk("R2", rw, 32'hA5A5_0001);
    solo(2, 2'b10, 32'd4, 0, 0, "R8", rl, rw);
    chk("R8", rl, {32'd0, 32'hA5A5_0001, 32'd0, 32'd0});
  endtask

  task automatic t_line();
    logic [127:0] rl; logic [31:0] rw;
    logic [127:0] ln;
    ln = {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000};
    solo(2, 2'b11, 32'd12, 0, ln, "R7", rl, rw);
    solo(1, 2'b10, 32'd15, 0, 0, "R7", rl, rw);
    chk("R7", rl, ln);
    solo(0, 2'b10, 32'd13, 0, 0, "R7", rl, rw);
    chk("R7", rl, ln);
    solo(0, 2'b00, 32'd13, 0, 0, "R1", rl, rw);
    chk("R1", rw, 32'h2222_0001);
  endtask

  task automatic t_contend();
    logic [127:0] rl; logic [31:0] rw;
    req_valid[0] = 1; req_kind[0] = 2'b01; req_addr[0] = 32'd8; req_wword[0] = 32'hD0D0_0008;
    req_valid[1] = 1; req_kind[1] = 2'b01; req_addr[1] = 32'd9; req_wword[1] = 32'hF0F0_0009;
    for (int c = 0; c < 8; c++) begin
      #1;
      if (c <= 3) chk("R4", rsp[0], (c == 3) ? 2'd1 : 2'd0);
      chk("R5", rsp[1], (c == 7) ? 2'd1 : 2'd0);
      @(negedge clk);
      if (c == 3) req_valid[0] = 0;
    end
    req_valid[1] = 0;
    solo(2, 2'b10, 32'd10, 0, 0, "R4", rl, rw);
    chk("R4", rl, {64'd0, 32'hF0F0_0009, 32'hD0D0_0008});
  endtask

  task automatic t_side();
    logic [127:0] rl; logic [31:0] rw;
    req_valid[0] = 1; req_kind[0] = 2'b00; req_addr[0] = 32'd20;
    side_valid = 1; side_line_op = 0; side_addr = 32'd20; side_wword = 32'h5151_0020;
    for (int c = 0; c <= LAT; c++) begin
      #1;
      if (c == 0) chk("R6", side_rsp, 2'd1);
      chk("R6", rsp[0], (c == LAT) ? 2'd1 : 2'd0);
      if (c == LAT) chk("R6", rd_word, 32'h5151_0020);
      @(negedge clk);
      side_valid = 0;
    end
    req_valid[0] = 0;
    // collision on the commit edge
    req_valid[0] = 1; req_kind[0] = 2'b01; req_addr[0] = 32'd21; req_wword[0] = 32'hDEAD_0021;
    for (int c = 0; c <= LAT; c++) begin
      if (c == LAT) begin
        side_valid = 1; side_addr = 32'd21; side_wword = 32'h5EDE_0021;
      end
      #1;
      chk("R6", rsp[0], (c == LAT) ? 2'd1 : 2'd0);
      @(negedge clk);
    end
    req_valid[0] = 0; side_valid = 0;
    solo(1, 2'b00, 32'd21, 0, 0, "R6", rl, rw);
    chk("R6", rw, 32'h5EDE_0021);
  endtask

  task automatic t_wrap();
    logic [127:0] rl; logic [31:0] rw;
    solo(0, 2'b01, 32'd69, 32'h7777_0005, 0, "R1", rl, rw);
    solo(1, 2'b00, 32'd5, 0, 0, "R1", rl, rw);
    chk("R1", rw, 32'h7777_0005);
    solo(2, 2'b01, 32'hFFFF_FFFF, 32'h8888_003F, 0, "R1", rl, rw);
    solo(0, 2'b10, 32'd60, 0, 0, "R1", rl, rw);
    chk("R1", rl, {32'h8888_003F, 96'd0});
  endtask

  task automatic t_zero();
    zv[0] = 1; zk[0] = 2'b01; za[0] = 32'd3; zw[0] = 32'h2100_0001;
    zv[1] = 1; zk[1] = 2'b01; za[1] = 32'd3; zw[1] = 32'h2200_0002;
    #1;
    chk("R3", zrsp[0], 2'd1);
    chk("R5", zrsp[1], 2'd0);
    @(negedge clk);
    zv[0] = 0;
    #1;
    chk("R5", zrsp[1], 2'd1);
    @(negedge clk);
    zv[1] = 0;
    zv[0] = 1; zk[0] = 2'b00; za[0] = 32'd3;
    #1;
    chk("R3", zrsp[0], 2'd1);
    chk("R3", z_rd_word, 32'h2200_0002);
    @(negedge clk);
    zv[0] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    req_valid = '0; req_kind = '0; req_addr = '0; req_wword = '0; req_wline = '0;
    side_valid = 0; side_line_op = 0; side_addr = '0; side_wword = '0; side_wline = '0;
    zv = '0; zk = '0; za = '0; zw = '0; zl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_word();
    t_line();
    t_contend();
    t_side();
    t_wrap();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule